// File: doc/BRIEF.md
# Min-Sum Variable Node Processor

This block performs the variable-node update of an iterative min-sum decoder for low-density parity-check codes. Each cycle in which `in_valid` is high it takes one quantized channel value and `WC` messages from the check nodes attached to this variable. It forms their total, the posterior value Z. For every attached edge it forms an extrinsic message that leaves out the message which arrived on that same edge. It also gives a hard-decision bit. A surrounding decoder routes messages between nodes and schedules iterations. This block holds no message memory.

All messages cross the block boundary as sign-magnitude words `MSG_W` bits wide. The most significant bit is the sign (1 means negative) and the lower `MSG_W-1` bits are the magnitude. Inside, values are converted to two's complement, summed at a width wide enough that overflow cannot occur, then clamped back to the message range and returned in sign-magnitude. The results are registered, so an input accepted on one clock edge appears at the outputs after exactly one cycle. For the first decoding pass, `first_iter` forces every incoming check message to zero, and each outgoing message is then the channel value.

Top module: `minsum_vn`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `z_out` (two's complement, `ACC_W` bits) equals the channel value plus the sum of all `WC` incoming check messages, with no clamping.
- R2: Outgoing lane j (bits `[j*MSG_W +: MSG_W]` of `beta_sm`) equals Z minus incoming lane j of `alpha_sm`, in sign-magnitude, when that difference lies within ±(2^(MSG_W-1)-1).
- R3: With `first_iter` high, every incoming check message is taken as zero: Z equals the channel value and every outgoing lane equals the channel value.
- R4: An outgoing difference beyond the message range is clamped to magnitude 2^(MSG_W-1)-1 (15 for 5 bits), keeping the sign of the unclamped value.
- R5: An input word with the sign bit set and magnitude zero is read as the value zero.
- R6: No outgoing lane ever carries negative zero (sign bit 1, magnitude 0). A zero result leaves as all-zero bits.
- R7: `hard_bit` is 1 exactly when Z is negative, and 0 when Z is zero or positive.
- R8: `out_valid` equals `in_valid` delayed by one cycle. After a cycle with `in_valid` low, `z_out`, `beta_sm` and `hard_bit` keep their previous values.
- R9: While `rst_n` is low, `out_valid`, `z_out`, `beta_sm` and `hard_bit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| first_iter | input | 1 | Treat all incoming check messages as zero |
| lambda_sm | input | MSG_W | Channel value, sign-magnitude |
| alpha_sm | input | WC*MSG_W | Incoming check messages, lane j at `[j*MSG_W +: MSG_W]` |
| out_valid | output | 1 | Registered outputs hold a new result |
| beta_sm | output | WC*MSG_W | Outgoing extrinsic messages, sign-magnitude, same lane layout |
| z_out | output | ACC_W | Posterior total Z, two's complement, ACC_W = MSG_W + clog2(WC+1) |
| hard_bit | output | 1 | Hard decision: 1 when Z is negative |

## Verification
The bench uses the default configuration: 5-bit messages and a column weight of 3, which gives a 7-bit accumulator. The channel value and the first check message each run through all 32 encodings, including negative zero. The other two lanes step through zero, negative zero, both extreme magnitudes and a mid value. This makes the largest positive and negative totals, both clamping directions, exact zero results and the negative-zero input case all occur on every lane. Expected values are worked out in plain integer arithmetic. Directed cases cover the first-iteration override, the hold behaviour with `in_valid` low, and the reset state.

// File: rtl/minsum_vn_pkg.sv
package minsum_vn_pkg;

    localparam int VN_MSG_W_DEFAULT = 5;
    localparam int VN_WC_DEFAULT    = 3;

    // Accumulator width that holds (wc+1) maximum magnitudes plus sign.
    function automatic int vn_acc_width(input int msg_w, input int wc);
        return msg_w + $clog2(wc + 1);
    endfunction

endpackage

// File: rtl/vn_sm_to_tc.sv
module vn_sm_to_tc #(
    parameter int MSG_W = 5,
    parameter int OUT_W = 7
) (
    input  logic [MSG_W-1:0]        sm_in,
    output logic signed [OUT_W-1:0] tc_out
);
    logic signed [OUT_W-1:0] mag_ext;

    always_comb begin
        mag_ext = $signed({{(OUT_W-MSG_W+1){1'b0}}, sm_in[MSG_W-2:0]});
        // A signed zero magnitude negates to zero, so -0 reads as 0.
        tc_out  = sm_in[MSG_W-1] ? -mag_ext : mag_ext;
    end
endmodule

// File: rtl/vn_tc_sat_to_sm.sv
module vn_tc_sat_to_sm #(
    parameter int IN_W  = 7,
    parameter int MSG_W = 5
) (
    input  logic signed [IN_W-1:0] tc_in,
    output logic [MSG_W-1:0]       sm_out
);
    localparam logic [IN_W:0] MAG_MAX = (IN_W+1)'((1 << (MSG_W-1)) - 1);

    logic          is_neg;
    logic [IN_W:0] wide;
    logic [IN_W:0] mag;
    logic [MSG_W-2:0] mag_c;

    always_comb begin
        is_neg = tc_in[IN_W-1];
        wide   = {tc_in[IN_W-1], tc_in};
        mag    = is_neg ? (~wide + 1'b1) : wide;
        if (mag > MAG_MAX) begin
            mag_c = MAG_MAX[MSG_W-2:0];
        end else begin
            mag_c = mag[MSG_W-2:0];
        end
        sm_out = {is_neg && (mag != '0), mag_c};
    end
endmodule

// File: rtl/minsum_vn.sv
module minsum_vn
    import minsum_vn_pkg::*;
#(
    parameter int MSG_W = VN_MSG_W_DEFAULT,
    parameter int WC    = VN_WC_DEFAULT,
    localparam int ACC_W = vn_acc_width(MSG_W, WC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    first_iter,
    input  logic [MSG_W-1:0]        lambda_sm,
    input  logic [WC*MSG_W-1:0]     alpha_sm,
    output logic                    out_valid,
    output logic [WC*MSG_W-1:0]     beta_sm,
    output logic [ACC_W-1:0]        z_out,
    output logic                    hard_bit
);

    typedef struct packed {
        logic                    vld;
        logic                    hard;
        logic signed [ACC_W-1:0] z;
        logic [WC*MSG_W-1:0]     beta;
    } vn_state_t;

    vn_state_t st_d, st_q;

    logic signed [ACC_W-1:0] lambda_tc;
    logic signed [ACC_W-1:0] alpha_tc [WC];
    logic signed [ACC_W-1:0] extr_tc  [WC];
    logic signed [ACC_W-1:0] z_sum;
    logic [WC*MSG_W-1:0]     beta_sat;

    vn_sm_to_tc #(.MSG_W(MSG_W), .OUT_W(ACC_W)) u_lambda_cvt (
        .sm_in  (lambda_sm),
        .tc_out (lambda_tc)
    );

    for (genvar j = 0; j < WC; j++) begin : g_edge
        logic [MSG_W-1:0] alpha_gated;
        assign alpha_gated = first_iter ? '0 : alpha_sm[j*MSG_W +: MSG_W];

        vn_sm_to_tc #(.MSG_W(MSG_W), .OUT_W(ACC_W)) u_alpha_cvt (
            .sm_in  (alpha_gated),
            .tc_out (alpha_tc[j])
        );

        // Extrinsic value: total minus this edge's own contribution.
        assign extr_tc[j] = z_sum - alpha_tc[j];

        vn_tc_sat_to_sm #(.IN_W(ACC_W), .MSG_W(MSG_W)) u_beta_cvt (
            .tc_in  (extr_tc[j]),
            .sm_out (beta_sat[j*MSG_W +: MSG_W])
        );
    end

    always_comb begin
        z_sum = lambda_tc;
        for (int j = 0; j < WC; j++) begin
            z_sum = z_sum + alpha_tc[j];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.z    = z_sum;
            st_d.hard = z_sum[ACC_W-1];
            st_d.beta = beta_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign beta_sm   = st_q.beta;
    assign z_out     = st_q.z;
    assign hard_bit  = st_q.hard;

endmodule

// File: rtl/minsum_vn_checker.sv
module minsum_vn_checker
    import minsum_vn_pkg::*;
#(
    parameter int MSG_W = VN_MSG_W_DEFAULT,
    parameter int WC    = VN_WC_DEFAULT,
    localparam int ACC_W = vn_acc_width(MSG_W, WC)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                first_iter,
    input logic [MSG_W-1:0]    lambda_sm,
    input logic                out_valid,
    input logic [WC*MSG_W-1:0] beta_sm,
    input logic [ACC_W-1:0]    z_out,
    input logic                hard_bit
);
    localparam logic [MSG_W-1:0] NEG_ZERO = {1'b1, {(MSG_W-1){1'b0}}};

    a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(beta_sm) && $stable(z_out) && $stable(hard_bit)));

    a_r7_hard_sign: assert property (@(posedge clk) disable iff (!rst_n)
        hard_bit == z_out[ACC_W-1]);

    a_r3_first_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && first_iter && lambda_sm != NEG_ZERO)
            |=> (beta_sm[MSG_W-1:0] == $past(lambda_sm)));

    for (genvar j = 0; j < WC; j++) begin : g_lane
        a_r6_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
            beta_sm[j*MSG_W +: MSG_W] != NEG_ZERO);
    end

endmodule

bind minsum_vn minsum_vn_checker #(.MSG_W(MSG_W), .WC(WC)) u_vn_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .first_iter (first_iter),
    .lambda_sm  (lambda_sm),
    .out_valid  (out_valid),
    .beta_sm    (beta_sm),
    .z_out      (z_out),
    .hard_bit   (hard_bit)
);

// File: tb/minsum_vn_test.sv
`timescale 1ns/1ps
module minsum_vn_test;
    localparam int MSG_W = 5;
    localparam int WC    = 3;
    localparam int ACC_W = 7;
    localparam int MAXM  = 15;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                first_iter = 1'b0;
    logic [MSG_W-1:0]    lambda_sm = '0;
    logic [WC*MSG_W-1:0] alpha_sm = '0;
    logic                out_valid;
    logic [WC*MSG_W-1:0] beta_sm;
    logic [ACC_W-1:0]    z_out;
    logic                hard_bit;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    minsum_vn #(.MSG_W(MSG_W), .WC(WC)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_iter(first_iter),
        .lambda_sm(lambda_sm), .alpha_sm(alpha_sm), .out_valid(out_valid),
        .beta_sm(beta_sm), .z_out(z_out), .hard_bit(hard_bit)
    );

    function automatic int sm_val(input logic [4:0] w);
        int m;
        m = int'(w[3:0]);
        return w[4] ? -m : m;
    endfunction

    function automatic int clamp(input int v);
        if (v > MAXM) return MAXM;
        if (v < -MAXM) return -MAXM;
        return v;
    endfunction

    function automatic logic [4:0] to_sm(input int v);
        return (v < 0) ? {1'b1, 4'(-v)} : {1'b0, 4'(v)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic run_vec(input logic [4:0] lam, input logic [4:0] a0,
                           input logic [4:0] a1, input logic [4:0] a2, input bit fi);
        int a [WC];
        int z;
        int d;
        logic [4:0] eb;
        a[0] = fi ? 0 : sm_val(a0);
        a[1] = fi ? 0 : sm_val(a1);
        a[2] = fi ? 0 : sm_val(a2);
        z = sm_val(lam) + a[0] + a[1] + a[2];
        in_valid = 1'b1; first_iter = fi; lambda_sm = lam;
        alpha_sm = {a2, a1, a0};
        @(negedge clk);
        chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
        chk($signed(z_out) == z, fi ? "R3" : "R1", int'($signed(z_out)), z);
        chk(hard_bit == (z < 0), "R7", int'(hard_bit), int'(z < 0));
        for (int j = 0; j < WC; j++) begin
            d  = z - a[j];
            eb = to_sm(clamp(d));
            if (fi)
                chk(beta_sm[j*MSG_W +: MSG_W] == eb, "R3", int'(beta_sm[j*MSG_W +: MSG_W]), int'(eb));
            else if (d > MAXM || d < -MAXM)
                chk(beta_sm[j*MSG_W +: MSG_W] == eb, "R4", int'(beta_sm[j*MSG_W +: MSG_W]), int'(eb));
            else if (d == 0)
                chk(beta_sm[j*MSG_W +: MSG_W] == 5'b00000, "R6", int'(beta_sm[j*MSG_W +: MSG_W]), 0);
            else
                chk(beta_sm[j*MSG_W +: MSG_W] == eb, "R2", int'(beta_sm[j*MSG_W +: MSG_W]), int'(eb));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] pat [5];
        logic [WC*MSG_W-1:0] held_beta;
        logic [ACC_W-1:0] held_z;
        logic held_h;
        pat[0] = 5'h00; pat[1] = 5'h0F; pat[2] = 5'h1F; pat[3] = 5'h17; pat[4] = 5'h10;

        // R9: reset state
        repeat (3) @(negedge clk);
        in_valid = 1'b1; lambda_sm = 5'h0F; alpha_sm = {3{5'h0F}};
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
        chk(z_out == '0, "R9", int'(z_out), 0);
        chk(beta_sm == '0, "R9", int'(beta_sm), 0);
        chk(hard_bit == 1'b0, "R9", int'(hard_bit), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R5: negative-zero inputs read as zero
        run_vec(5'h10, 5'h10, 5'h03, 5'h10, 1'b0);
        chk(z_out == 7'd3, "R5", int'(z_out), 3);
        run_vec(5'h10, 5'h10, 5'h10, 5'h10, 1'b0);
        chk(beta_sm == '0 && z_out == '0, "R5", int'(beta_sm), 0);

        // R3: first pass ignores check messages
        run_vec(5'h19, 5'h0F, 5'h1F, 5'h07, 1'b1);
        chk(beta_sm == {3{5'h19}}, "R3", int'(beta_sm), int'({3{5'h19}}));
        run_vec(5'h10, 5'h0F, 5'h0F, 5'h0F, 1'b1);
        chk(beta_sm == '0, "R3", int'(beta_sm), 0);

        // R8: hold when no new input
        run_vec(5'h1C, 5'h02, 5'h15, 5'h0B, 1'b0);
        held_beta = beta_sm; held_z = z_out; held_h = hard_bit;
        in_valid = 1'b0; lambda_sm = 5'h0F; alpha_sm = {3{5'h0F}};
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
        chk(beta_sm == held_beta, "R8", int'(beta_sm), int'(held_beta));
        chk(z_out == held_z && hard_bit == held_h, "R8", int'(z_out), int'(held_z));
        @(negedge clk);
        chk(beta_sm == held_beta, "R8", int'(beta_sm), int'(held_beta));

        // Sweep: R1 R2 R4 R6 R7
        for (int l = 0; l < 32; l++)
            for (int x = 0; x < 32; x++)
                for (int p = 0; p < 5; p++)
                    for (int q = 0; q < 5; q++)
                        run_vec(5'(l), 5'(x), pat[p], pat[q], 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule